// File: doc/BRIEF.md
# Media Port Poll Responder

This block is the poll answering logic in a companion device attached to a polled media port. The port host starts each bus cycle with a first-cycle code byte. When that code marks a poll cycle, the responder must place one command byte on the data bus while the acknowledge window is open. It returns 00h when there is nothing to ask for.

Four local sources can raise a request:
- a display-data FIFO that needs filling,
- a compressed-video buffer that holds data to send,
- an interrupt event,
- a register read whose data has come back after the host issued it.

Each request is held in a flag until the port starts the matching transaction. Completion of the transaction is signalled back to the local source as a one-cycle take pulse.

A register read happens in two parts. The host first sends an issue cycle. Read-data-ready is reported only after that issue cycle has been seen and the local register data has arrived. The flag stays up until the host runs the receive cycle.

Top module: `mp_poll_responder`

## Requirements
- R1: `resp_oe` is high only while `ack_win` is high and the most recent decoded cycle (`cyc_valid` high) was a poll. While `resp_oe` is low, `resp_data` is 00h.
- R2: A poll answered with no request pending returns 00h.
- R3: In every response byte, bits 7, 6, 5 and 2 are zero. The request bits are: bit 0 display read, bit 1 compressed-video write, bit 3 interrupt, bit 4 read data ready.
- R4: Each response has at most one bit set, chosen in this priority order: display read, then read data ready, then compressed-video write, then interrupt.
- R5: A display request (`disp_need` sampled high) stays reported until a display-read cycle, code 11xx1000, is decoded. `disp_take` pulses in the cycle after that decode.
- R6: A compressed-video request (`vid_ready` sampled high) stays reported until a write cycle, code 01xx0001, is decoded. `vid_take` pulses in the cycle after that decode.
- R7: `rd_data_valid` marks read data ready only after a read-issue cycle, code 01xx1111. It is ignored when no issue is outstanding.
- R8: Read data ready clears when a receive cycle, code 11xx1111, is decoded while it is set. `rd_take` pulses in the cycle after that decode. A receive cycle at any other time has no effect.
- R9: The interrupt request clears once it has been reported in a poll response. While it is outranked by another request it stays pending.
- R10: The response byte is captured when the poll code is decoded. It does not change until the next decoded cycle, even if requests change in the meantime.
- R11: Bits 5:4 of every cycle code are ignored when decoding. A poll cycle has code 11xx0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | First cycle of a port transaction; `cyc_code` is valid |
| cyc_code | input | 8 | First-cycle code byte |
| ack_win | input | 1 | Acknowledge window open |
| disp_need | input | 1 | Display FIFO wants data |
| vid_ready | input | 1 | Compressed-video buffer has data |
| irq_evt | input | 1 | Interrupt event pulse |
| rd_data_valid | input | 1 | Register read data available |
| resp_data | output | RESP_W | Response byte to the bus |
| resp_oe | output | 1 | Drive enable for `resp_data` |
| disp_take | output | 1 | Display-read cycle started |
| vid_take | output | 1 | Compressed-video write cycle started |
| rd_take | output | 1 | Read data handed over by a receive cycle |

## Verification
Most flag errors show up on the bus at the next poll's acknowledge window, a few cycles after the fault:
- A lost flag appears as a missing bit.
- A stuck flag appears as a repeated bit after its take pulse.
- A wrong priority appears as the wrong single bit.

A read tracker in the wrong state shows up in one of two ways. Either the ready bit appears without an issue cycle, or a receive cycle produces no `rd_take` pulse one cycle after it is decoded.

An interrupt flag that never clears shows up as bit 3 on two polls in a row.

// File: rtl/mp_poll_pkg.sv
package mp_poll_pkg;

   localparam int unsigned CODE_W = 8;

   // Response bit positions (the host decodes these)
   localparam int unsigned BIT_DISP = 0;
   localparam int unsigned BIT_VID  = 1;
   localparam int unsigned BIT_IRQ  = 3;
   localparam int unsigned BIT_RDY  = 4;

   // Cycle code patterns: match when (code & MASK) == VAL
   localparam logic [7:0] MASK_LOW = 8'b1100_1111;
   localparam logic [7:0] VAL_POLL = 8'b1100_0000;
   localparam logic [7:0] VAL_ISSU = 8'b0100_1111;
   localparam logic [7:0] VAL_RECV = 8'b1100_1111;
   localparam logic [7:0] VAL_VIDW = 8'b0100_0001;
   localparam logic [7:0] VAL_DISR = 8'b1100_1000;
   localparam logic [7:0] MASK_WR  = 8'b1100_0000;
   localparam logic [7:0] VAL_WR   = 8'b0000_0000;

   typedef enum logic [2:0] {
      CK_NONE,
      CK_POLL,
      CK_WRITE,
      CK_ISSUE,
      CK_RECV,
      CK_VIDW,
      CK_DISR
   } cyc_kind_t;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_WAIT,
      RD_READY
   } rd_state_t;

   typedef struct packed {
      logic disp;
      logic rdy;
      logic vid;
      logic irq;
   } req_flags_t;

endpackage

// File: rtl/mp_cycle_decode.sv
module mp_cycle_decode
   import mp_poll_pkg::*;
(
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   output cyc_kind_t         kind
);

   function automatic logic hit(input logic [7:0] c, input logic [7:0] m,
                                input logic [7:0] v);
      return (c & m) == v;
   endfunction

   always_comb begin
      kind = CK_NONE;
      if (valid) begin
         if      (hit(code, MASK_LOW, VAL_POLL)) kind = CK_POLL;
         else if (hit(code, MASK_LOW, VAL_RECV)) kind = CK_RECV;
         else if (hit(code, MASK_LOW, VAL_ISSU)) kind = CK_ISSUE;
         else if (hit(code, MASK_LOW, VAL_VIDW)) kind = CK_VIDW;
         else if (hit(code, MASK_LOW, VAL_DISR)) kind = CK_DISR;
         else if (hit(code, MASK_WR,  VAL_WR))   kind = CK_WRITE;
      end
   end

endmodule

// File: rtl/mp_req_track.sv
module mp_req_track
   import mp_poll_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cyc_kind_t  kind,
   input  logic       disp_need,
   input  logic       vid_ready,
   input  logic       irq_evt,
   input  logic       rd_data_valid,
   input  logic       irq_reported,
   output req_flags_t flags,
   output logic       disp_take,
   output logic       vid_take,
   output logic       rd_take
);

   logic      disp_q, vid_q, irq_q;
   rd_state_t rd_q, rd_d;
   logic      recv_hit;

   assign recv_hit = (kind == CK_RECV) && (rd_q == RD_READY);

   always_comb begin
      rd_d = rd_q;
      if (kind == CK_ISSUE)                          rd_d = RD_WAIT;
      else if (recv_hit)                             rd_d = RD_IDLE;
      else if ((rd_q == RD_WAIT) && rd_data_valid)   rd_d = RD_READY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_q    <= 1'b0;
         vid_q     <= 1'b0;
         irq_q     <= 1'b0;
         rd_q      <= RD_IDLE;
         disp_take <= 1'b0;
         vid_take  <= 1'b0;
         rd_take   <= 1'b0;
      end else begin
         disp_q    <= (disp_q | disp_need) & ~(kind == CK_DISR);
         vid_q     <= (vid_q | vid_ready) & ~(kind == CK_VIDW);
         irq_q     <= irq_evt | (irq_q & ~irq_reported);
         rd_q      <= rd_d;
         disp_take <= (kind == CK_DISR);
         vid_take  <= (kind == CK_VIDW);
         rd_take   <= recv_hit;
      end
   end

   assign flags.disp = disp_q;
   assign flags.vid  = vid_q;
   assign flags.irq  = irq_q;
   assign flags.rdy  = (rd_q == RD_READY);

endmodule

// File: rtl/mp_resp_encode.sv
module mp_resp_encode
   import mp_poll_pkg::*;
#(
   parameter int unsigned RESP_W        = 8,
   parameter bit          PRIORITY_ONLY = 1'b1
)(
   input  req_flags_t        flags,
   output logic [RESP_W-1:0] byte_out,
   output logic              irq_sel
);

   generate
      if (PRIORITY_ONLY) begin : g_single
         always_comb begin
            byte_out = '0;
            irq_sel  = 1'b0;
            if      (flags.disp) byte_out[BIT_DISP] = 1'b1;
            else if (flags.rdy)  byte_out[BIT_RDY]  = 1'b1;
            else if (flags.vid)  byte_out[BIT_VID]  = 1'b1;
            else if (flags.irq) begin
               byte_out[BIT_IRQ] = 1'b1;
               irq_sel           = 1'b1;
            end
         end
      end else begin : g_merged
         always_comb begin
            byte_out           = '0;
            byte_out[BIT_DISP] = flags.disp;
            byte_out[BIT_RDY]  = flags.rdy;
            byte_out[BIT_VID]  = flags.vid;
            byte_out[BIT_IRQ]  = flags.irq;
            irq_sel            = flags.irq;
         end
      end
   endgenerate

endmodule

// File: rtl/mp_poll_responder.sv
module mp_poll_responder
   import mp_poll_pkg::*;
#(
   parameter int unsigned RESP_W        = 8,
   parameter bit          PRIORITY_ONLY = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_valid,
   input  logic [7:0]        cyc_code,
   input  logic              ack_win,
   input  logic              disp_need,
   input  logic              vid_ready,
   input  logic              irq_evt,
   input  logic              rd_data_valid,
   output logic [RESP_W-1:0] resp_data,
   output logic              resp_oe,
   output logic              disp_take,
   output logic              vid_take,
   output logic              rd_take
);

   localparam int unsigned TOP_BIT = BIT_RDY;

   generate
      if (RESP_W <= TOP_BIT) begin : g_bad_width
         $error("RESP_W must exceed the highest request bit position");
      end
   endgenerate

   cyc_kind_t         kind;
   req_flags_t        flags;
   logic [RESP_W-1:0] enc_byte;
   logic              irq_sel;
   logic              irq_reported;
   logic [RESP_W-1:0] held_q;
   logic              poll_q;

   mp_cycle_decode u_dec (
      .valid (cyc_valid),
      .code  (cyc_code),
      .kind  (kind)
   );

   mp_resp_encode #(
      .RESP_W        (RESP_W),
      .PRIORITY_ONLY (PRIORITY_ONLY)
   ) u_enc (
      .flags    (flags),
      .byte_out (enc_byte),
      .irq_sel  (irq_sel)
   );

   assign irq_reported = (kind == CK_POLL) && irq_sel;

   mp_req_track u_trk (
      .clk           (clk),
      .rst_n         (rst_n),
      .kind          (kind),
      .disp_need     (disp_need),
      .vid_ready     (vid_ready),
      .irq_evt       (irq_evt),
      .rd_data_valid (rd_data_valid),
      .irq_reported  (irq_reported),
      .flags         (flags),
      .disp_take     (disp_take),
      .vid_take      (vid_take),
      .rd_take       (rd_take)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
         poll_q <= 1'b0;
      end else if (cyc_valid) begin
         poll_q <= (kind == CK_POLL);
         if (kind == CK_POLL) held_q <= enc_byte;
      end
   end

   assign resp_oe   = ack_win & poll_q;
   assign resp_data = resp_oe ? held_q : '0;

endmodule

// File: rtl/mp_poll_responder_chk.sv
module mp_poll_responder_chk #(
   parameter int unsigned RESP_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_valid,
   input logic              ack_win,
   input logic [RESP_W-1:0] resp_data,
   input logic              resp_oe,
   input logic              disp_take,
   input logic              vid_take,
   input logic              rd_take
);

   p_oe_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_win |-> !resp_oe);

   p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_oe |-> (resp_data == '0));

   p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_data[7:5] == 3'b000) && !resp_data[2]);

   p_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(resp_data));

   p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_oe && !cyc_valid) |=> (!resp_oe || $stable(resp_data)));

   p_disp_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_take |-> $past(cyc_valid));

   p_vid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vid_take |-> $past(cyc_valid));

   p_recv_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |-> $past(cyc_valid));

endmodule

bind mp_poll_responder mp_poll_responder_chk #(.RESP_W(RESP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_valid (cyc_valid),
   .ack_win   (ack_win),
   .resp_data (resp_data),
   .resp_oe   (resp_oe),
   .disp_take (disp_take),
   .vid_take  (vid_take),
   .rd_take   (rd_take)
);

// File: tb/test_mp_poll_responder.sv
`timescale 1ns/1ps
module test_mp_poll_responder;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cyc_valid, ack_win, disp_need, vid_ready, irq_evt, rd_data_valid;
   logic [7:0] cyc_code;
   logic [7:0] resp_data;
   logic       resp_oe, disp_take, vid_take, rd_take;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   mp_poll_responder i_mp_poll_responder (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
      .ack_win(ack_win), .disp_need(disp_need), .vid_ready(vid_ready),
      .irq_evt(irq_evt), .rd_data_valid(rd_data_valid),
      .resp_data(resp_data), .resp_oe(resp_oe), .disp_take(disp_take),
      .vid_take(vid_take), .rd_take(rd_take)
   );

   // kind ids: 0 none, 1 poll, 2 write, 3 issue, 4 receive, 5 video, 6 display
   localparam logic [7:0] M = 8'hCF;

   function automatic int kind_of(input logic [7:0] c);
      if ((c & M) == 8'hC0) return 1;
      if ((c & M) == 8'hCF) return 4;
      if ((c & M) == 8'h4F) return 3;
      if ((c & M) == 8'h41) return 5;
      if ((c & M) == 8'hC8) return 6;
      if ((c & 8'hC0) == 8'h00) return 2;
      return 0;
   endfunction

   function automatic logic [7:0] mk(input int k);
      logic [7:0] base, msk;
      msk = M;
      case (k)
         1: base = 8'hC0;
         3: base = 8'h4F;
         4: base = 8'hCF;
         5: base = 8'h41;
         6: base = 8'hC8;
         default: begin base = 8'h00; msk = 8'hC0; end
      endcase
      return base | (8'($urandom) & ~msk);
   endfunction

   // reference state
   logic       m_disp, m_vid, m_irq, m_act, m_dt, m_vt, m_rt;
   int         m_rd;
   logic [7:0] m_byte;

   function automatic logic [7:0] pick();
      if (m_disp)    return 8'h01;
      if (m_rd == 2) return 8'h10;
      if (m_vid)     return 8'h02;
      if (m_irq)     return 8'h08;
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_disp = 0; m_vid = 0; m_irq = 0; m_act = 0; m_rd = 0;
      m_byte = 0; m_dt = 0; m_vt = 0; m_rt = 0;
   endtask

   task automatic step(input logic v, input logic [7:0] code, input logic ack,
                       input logic dn, input logic vr, input logic ir,
                       input logic rdv, input string tag);
      int k;
      logic [7:0] e, eb;
      @(negedge clk);
      cyc_valid = v; cyc_code = code; ack_win = ack; disp_need = dn;
      vid_ready = vr; irq_evt = ir; rd_data_valid = rdv;
      #0.5;
      eb = (ack && m_act) ? m_byte : 8'h00;
      chk("R1 oe", {7'd0, resp_oe}, {7'd0, ack && m_act});
      chk(tag, resp_data, eb);
      chk("R5 disp_take", {7'd0, disp_take}, {7'd0, m_dt});
      chk("R6 vid_take",  {7'd0, vid_take},  {7'd0, m_vt});
      chk("R8 rd_take",   {7'd0, rd_take},   {7'd0, m_rt});
      k = v ? kind_of(code) : 0;
      e = pick();
      m_dt = (k == 6);
      m_vt = (k == 5);
      m_rt = (k == 4) && (m_rd == 2);
      m_disp = (m_disp | dn) & (k != 6);
      m_vid  = (m_vid | vr) & (k != 5);
      m_irq  = ir | (m_irq & !((k == 1) && (e == 8'h08)));
      if (k == 3)                 m_rd = 1;
      else if (m_rt)              m_rd = 0;
      else if (m_rd == 1 && rdv)  m_rd = 2;
      if (v) begin
         m_act = (k == 1);
         if (k == 1) m_byte = e;
      end
   endtask

   // poll, then one acknowledge cycle where the byte is checked
   task automatic poll(input string tag);
      step(1, mk(1), 0, 0, 0, 0, 0, tag);
      step(0, 8'h00, 1, 0, 0, 0, 0, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, 0, "R1");
   endtask

   initial begin
      #(4.0 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      rst_n = 0; cyc_valid = 0; cyc_code = 0; ack_win = 0; disp_need = 0;
      vid_ready = 0; irq_evt = 0; rd_data_valid = 0;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset oe", {7'd0, resp_oe}, 8'd0);
      chk("R1 reset data", resp_data, 8'd0);
      rst_n = 1;

      // R2 idle poll
      poll("R2 idle");
      // R7 data valid without issue is ignored
      step(0, 0, 0, 0, 0, 0, 1, "R7");
      poll("R7 no issue");
      // R7/R8 split read
      step(1, mk(3), 0, 0, 0, 0, 0, "R7");
      poll("R7 waiting");
      step(0, 0, 0, 0, 0, 0, 1, "R7");
      poll("R7 ready");
      step(1, mk(4), 0, 0, 0, 0, 0, "R8");
      idle(1);
      poll("R8 cleared");
      step(1, mk(4), 0, 0, 0, 0, 0, "R8 stray receive");
      idle(1);
      // R9 interrupt reported once
      step(0, 0, 0, 0, 0, 1, 0, "R9");
      poll("R9 first");
      poll("R9 second");
      // R4/R9 outranked interrupt
      step(0, 0, 0, 1, 1, 1, 0, "R4");
      poll("R4 disp first");
      step(1, mk(6), 0, 0, 0, 0, 0, "R5");
      poll("R4 vid next");
      step(1, mk(5), 0, 0, 0, 0, 0, "R6");
      poll("R9 irq kept");
      poll("R2 empty");
      // R10 byte frozen while requests change during window
      step(0, 0, 0, 0, 1, 0, 0, "R10");
      step(1, mk(1), 0, 0, 0, 0, 0, "R10");
      step(0, 0, 1, 1, 0, 1, 0, "R10 frozen");
      step(0, 0, 1, 0, 0, 0, 0, "R10 frozen");
      // R11 all don't-care variants of poll
      for (int j = 0; j < 4; j++) begin
         step(1, 8'hC0 | 8'(j << 4), 0, 0, 0, 0, 0, "R11");
         step(0, 0, 1, 0, 0, 0, 0, "R11 poll variant");
      end

      // constrained random (R3/R4)
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic v;
         r = $urandom_range(0, 9);
         v = ($urandom_range(0, 2) == 0);
         step(v, mk(r < 4 ? 1 : (r - 2)), $urandom_range(0, 1),
              ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 11) == 0), ($urandom_range(0, 3) == 0),
              "R3 R4 random");
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule